// File: doc/BRIEF.md
# Low-Address Guard and Prefix Swap Stage

This stage sits in front of memory. It takes real addresses and addresses that have already been translated, and decides for each one whether the access may proceed. A store that hits one of the two protected byte windows at the bottom of storage is rejected. The stage then returns a packed exception word that describes the failed access. Every other access is turned into an absolute address. For that, the first 8 KiB of real storage and the 8 KiB area named by the prefix register trade places; all other addresses pass through unchanged.

Each request is one cycle on `req_valid`. The result appears one clock later as a single-cycle pulse on exactly one of `rsp_ok` or `rsp_fault`. With a granted access come the read, write and execute permissions. It also carries a hint that tells a downstream translation cache not to keep a write-enabled copy of a page that contains a protected window.

Top module: `lowaddr_guard`

## Requirements
- R1: A store (`req_kind`=1) whose byte address is 0..511 or 4096..4607 faults while the guard is active. Reads (`req_kind`=0) and fetches (`req_kind`=2) never fault, and neither do stores at 512..4095 or from 4608 up.
- R2: The guard is active only when `lap_en`=1, and then either `dat_on`=0, or `dat_on`=1 with `priv_space`=0.
- R3: On a granted access, `rsp_winv` is 1 exactly when the guard is active and the address lies in page 0 or page 1 (0..8191).
- R4: On a fault, `rsp_tec` holds the address with bits 11:0 cleared, ORed with `req_asc` in bits 3:2, the store mark 0x400 and the guard mark 0x80. On a granted access, `rsp_tec` is 0.
- R5: A granted address below 0x2000 yields `rsp_abs` = address + `prefix`.
- R6: A granted address in [prefix, prefix+0x2000) that is not below 0x2000 yields `rsp_abs` = address − `prefix`.
- R7: Any other granted address passes through unchanged. With `prefix`=0 the mapping is the identity.
- R8: A granted access has `rsp_rd`, `rsp_wr` and `rsp_ex` all 1. A fault has all permission outputs and `rsp_abs` at 0.
- R9: A request accepted at a clock edge produces, at the next edge, exactly one of `rsp_ok`/`rsp_fault` for one cycle. With no request, neither is asserted.
- R10: While `rst` is high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Real byte address |
| req_kind | input | 2 | 0 read, 1 store, 2 instruction fetch |
| req_asc | input | 2 | Address-space-control value copied into the exception word |
| lap_en | input | 1 | Low-address guard enable |
| dat_on | input | 1 | Translation mode is on |
| priv_space | input | 1 | Private-space bit of the selected space descriptor |
| prefix | input | 64 | Prefix area origin, 8 KiB aligned |
| rsp_ok | output | 1 | Access granted |
| rsp_fault | output | 1 | Protection exception |
| rsp_abs | output | 64 | Absolute address |
| rsp_tec | output | 64 | Exception word |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| rsp_winv | output | 1 | Do-not-cache-writes hint |

## Verification
The stores are aimed at both edges of each protected window: 0, 511 and 512, and 4607 and 4608. This shows that the windows are byte-exact, not whole pages. The same low addresses are also repeated as reads and fetches, and under each combination of enable, translation mode and private space. This separates the access-type rule from the activation rule.

Addresses are placed below 0x2000, inside the prefix area at both ends, exactly at 0x2000, just past the prefix area, and at a high address, and the prefix is also set to 0. Together these show each branch of the swap and its boundaries. Idle and back-to-back requests check the single-pulse response.

// File: rtl/lap_pkg.sv
package lap_pkg;
    localparam int unsigned XLEN      = 64;
    localparam int unsigned PG_BITS   = 12;
    localparam int unsigned LOW_SPAN  = 512;
    localparam int unsigned SWAP_SPAN = 8192;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic winv;
    } perm_t;

    localparam logic [XLEN-1:0] TEC_LOAD_MARK  = XLEN'(64'h800);
    localparam logic [XLEN-1:0] TEC_STORE_MARK = XLEN'(64'h400);
    localparam logic [XLEN-1:0] TEC_GUARD_MARK = XLEN'(64'h080);
    localparam int unsigned     TEC_ASC_LSB    = 2;

    function automatic logic [XLEN-1:0] tec_pack(
        input logic [XLEN-1:0] addr,
        input logic [1:0]      asc,
        input logic            is_store,
        input logic            guard_hit
    );
        logic [XLEN-1:0] w;
        w = addr & ~((XLEN'(1) << PG_BITS) - XLEN'(1));
        w = w | (XLEN'(asc) << TEC_ASC_LSB);
        w = w | (is_store ? TEC_STORE_MARK : TEC_LOAD_MARK);
        if (guard_hit) w = w | TEC_GUARD_MARK;
        return w;
    endfunction
endpackage

// File: rtl/lap_window_check.sv
module lap_window_check
    import lap_pkg::*;
#(
    parameter int unsigned AW        = XLEN,
    parameter int unsigned PAGE_BITS = PG_BITS,
    parameter int unsigned LOW_BYTES = LOW_SPAN
) (
    input  logic [AW-1:0] addr,
    input  acc_kind_e     kind,
    input  logic          lap_en,
    input  logic          dat_on,
    input  logic          priv_space,
    output logic          guard_on,
    output logic          low_page,
    output logic          violation
);
    localparam logic [PAGE_BITS-1:0] LOW_LIM = PAGE_BITS'(LOW_BYTES);

    logic in_window;

    always_comb begin
        guard_on  = lap_en && (!dat_on || !priv_space);
        low_page  = (addr >> (PAGE_BITS + 1)) == '0;
        in_window = low_page && (addr[PAGE_BITS-1:0] < LOW_LIM);
        violation = guard_on && in_window && (kind == ACC_STORE);
    end
endmodule

// File: rtl/lap_prefix_swap.sv
module lap_prefix_swap
    import lap_pkg::*;
#(
    parameter int unsigned AW        = XLEN,
    parameter int unsigned SWAP_BYTES = SWAP_SPAN
) (
    input  logic [AW-1:0] raddr,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] abs_addr
);
    localparam logic [AW-1:0] WIN = AW'(SWAP_BYTES);

    logic [AW-1:0] delta;

    always_comb begin
        delta = raddr - prefix;
        if (raddr < WIN)
            abs_addr = raddr + prefix;
        else if (raddr >= prefix && delta < WIN)
            abs_addr = delta;
        else
            abs_addr = raddr;
    end
endmodule

// File: rtl/lowaddr_guard.sv
module lowaddr_guard
    import lap_pkg::*;
#(
    parameter int unsigned AW         = XLEN,
    parameter int unsigned PAGE_BITS  = PG_BITS,
    parameter int unsigned LOW_BYTES  = LOW_SPAN,
    parameter int unsigned SWAP_BYTES = SWAP_SPAN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [63:0]   req_addr,
    input  logic [1:0]    req_kind,
    input  logic [1:0]    req_asc,
    input  logic          lap_en,
    input  logic          dat_on,
    input  logic          priv_space,
    input  logic [63:0]   prefix,
    output logic          rsp_ok,
    output logic          rsp_fault,
    output logic [63:0]   rsp_abs,
    output logic [63:0]   rsp_tec,
    output logic          rsp_rd,
    output logic          rsp_wr,
    output logic          rsp_ex,
    output logic          rsp_winv
);
    acc_kind_e     kind;
    logic          guard_on, low_page, violation;
    logic [AW-1:0] mapped;
    perm_t         perm_n, perm_q;
    logic [AW-1:0] tec_n;

    assign kind = acc_kind_e'(req_kind);

    lap_window_check #(
        .AW(AW), .PAGE_BITS(PAGE_BITS), .LOW_BYTES(LOW_BYTES)
    ) u_win (
        .addr(req_addr), .kind(kind), .lap_en(lap_en), .dat_on(dat_on),
        .priv_space(priv_space), .guard_on(guard_on), .low_page(low_page),
        .violation(violation)
    );

    lap_prefix_swap #(
        .AW(AW), .SWAP_BYTES(SWAP_BYTES)
    ) u_swap (
        .raddr(req_addr), .prefix(prefix), .abs_addr(mapped)
    );

    always_comb begin
        perm_n = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, winv: 1'b0};
        if (guard_on && low_page) perm_n.winv = 1'b1;
        tec_n = tec_pack(req_addr, req_asc, kind == ACC_STORE, 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ok    <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_abs   <= '0;
            rsp_tec   <= '0;
            perm_q    <= '0;
        end else begin
            rsp_ok    <= req_valid && !violation;
            rsp_fault <= req_valid && violation;
            if (req_valid && !violation) begin
                rsp_abs <= mapped;
                rsp_tec <= '0;
                perm_q  <= perm_n;
            end else if (req_valid) begin
                rsp_abs <= '0;
                rsp_tec <= tec_n;
                perm_q  <= '0;
            end
        end
    end

    assign rsp_rd   = perm_q.rd;
    assign rsp_wr   = perm_q.wr;
    assign rsp_ex   = perm_q.ex;
    assign rsp_winv = perm_q.winv;

    // R9
    excl_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_ok && rsp_fault));
    // R9
    one_resp_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_ok || rsp_fault));
    // R9
    idle_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_ok || rsp_fault));
    // R2
    guard_off_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !lap_en) |=> !rsp_fault);
    // R1
    load_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 2'd1) |=> !rsp_fault);
    // R4
    tec_mark_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_tec[7] && rsp_tec[10] && !rsp_tec[11]));
    // R8
    grant_perm_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_ok |-> (rsp_rd && rsp_wr && rsp_ex));
endmodule

// File: tb/lowaddr_guard_test.sv
module lowaddr_guard_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [63:0] addr;
        logic [63:0] pfx;
        logic [1:0]  kind;
        logic        lap;
        logic        dat;
        logic        priv;
        logic [1:0]  asc;
        logic        fault;
        logic [63:0] abs_a;
        logic [63:0] tec;
        logic [3:0]  perm;
    } vec_t;

    localparam int NV = 21;
    localparam logic [63:0] P = 64'h3_0000;
    localparam vec_t VECS [NV] = '{
        '{64'h100,  P, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 64'h0,     64'h480,  4'b0000},
        '{64'h1100, P, 2'd1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 64'h0,     64'h148C, 4'b0000},
        '{64'h1100, P, 2'd1, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 64'h31100, 64'h0,    4'b1110},
        '{64'h100,  P, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 64'h30100, 64'h0,    4'b1111},
        '{64'h200,  P, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 64'h30200, 64'h0,    4'b1111},
        '{64'h11FF, P, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 64'h0,     64'h1484, 4'b0000},
        '{64'h1200, P, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 64'h31200, 64'h0,    4'b1111},
        '{64'h1FF,  P, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h301FF, 64'h0,    4'b1110},
        '{64'h30010,P, 2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 64'h10,    64'h0,    4'b1110},
        '{64'h31FFF,P, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h1FFF,  64'h0,    4'b1110},
        '{64'h32000,P, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h32000, 64'h0,    4'b1110},
        '{64'h2000, P, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h2000,  64'h0,    4'b1110},
        '{64'h1FFF, P, 2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 64'h31FFF, 64'h0,    4'b1111},
        '{64'h1234, 64'h0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h1234, 64'h0,  4'b1110},
        '{64'h5000, 64'h0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h5000, 64'h0,  4'b1110},
        '{64'h2100, P, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 64'h2100,  64'h0,    4'b1110},
        '{64'h100,  P, 2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 64'h30100, 64'h0,    4'b1111},
        '{64'h0,    P, 2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 64'h0,     64'h488,  4'b0000},
        '{64'hFFFF_0000_0000_1000, P, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0,
          64'hFFFF_0000_0000_1000, 64'h0, 4'b1110},
        '{64'h1FF,  64'h0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 64'h0,   64'h480,  4'b0000},
        '{64'h1000, P, 2'd1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 64'h31000, 64'h0,    4'b1110}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_asc = '0;
    logic        lap_en = 1'b0, dat_on = 1'b0, priv_space = 1'b0;
    logic [63:0] prefix = '0;
    logic        rsp_ok, rsp_fault, rsp_rd, rsp_wr, rsp_ex, rsp_winv;
    logic [63:0] rsp_abs, rsp_tec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lowaddr_guard uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_asc(req_asc), .lap_en(lap_en),
        .dat_on(dat_on), .priv_space(priv_space), .prefix(prefix),
        .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_abs(rsp_abs),
        .rsp_tec(rsp_tec), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex),
        .rsp_winv(rsp_winv)
    );

    task automatic check(input string tag, input logic [195:0] act, input logic [195:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [195:0] snap();
        return {62'b0, rsp_ok, rsp_fault, rsp_abs, rsp_tec,
                rsp_rd, rsp_wr, rsp_ex, rsp_winv};
    endfunction

    task automatic drive(input vec_t v);
        req_valid  = 1'b1;
        req_addr   = v.addr;
        prefix     = v.pfx;
        req_kind   = v.kind;
        lap_en     = v.lap;
        dat_on     = v.dat;
        priv_space = v.priv;
        req_asc    = v.asc;
    endtask

    function automatic logic [195:0] expect_of(input vec_t v);
        return {62'b0, !v.fault, v.fault, v.abs_a, v.tec, v.perm};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs cleared in reset
        check("R10 reset state", snap(), '0);
        rst = 1'b0;
        @(negedge clk);
        // R9: idle gives no response
        check("R9 idle", {snap()[133:132]}, '0);

        // R1 R2 R3 R4 R5 R6 R7 R8: table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R1-table vec%0d R4 R5 R6 R7 R8", i), snap(), expect_of(VECS[i]));
            @(posedge clk);
            @(negedge clk);
            // R9: response lasts one cycle
            check($sformatf("R9 pulse vec%0d", i), {194'b0, rsp_ok, rsp_fault}, '0);
        end

        // R9: back-to-back requests, fault then grant
        drive(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        check("R9 back-to-back first", snap(), expect_of(VECS[0]));
        drive(VECS[3]);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 back-to-back second", snap(), expect_of(VECS[3]));

        // R10: reset after activity clears outputs
        drive(VECS[1]);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 reset after use", snap(), '0);
        rst = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule